// File: doc/BRIEF.md
# Key-Protected Configuration Register Unit

This unit is a small register file on a simple memory-mapped bus that has separate write and read strobes. It holds two registers whose contents steer a flash interface. The first is a four-bit interface configuration register. The second is a wide timing register. Both registers are guarded. Software must first store a 16-bit key into a lock register. That opens a window that admits exactly one write to either guarded register, and then protection comes back by itself. No explicit lock command exists.

A write to a guarded register while the window is closed leaves the register unchanged and sets a sticky violation flag. Software finds the flag in a status register, and the flag clears when that register is read. Reads are never restricted. The configuration bits and the timing word are driven from their storage flops straight to output pins. Read data is registered and appears one cycle after the read strobe.

Top module: `keyed_cfg_regs`

## Requirements
- R1: After reset the four configuration outputs and the timing output are zero, the unit is locked, and the status register reads 0. The status register is at offset 0x40, with bit 0 = violation and bit 1 = window open.
- R2: A write to offset 0x44 whose low 16 data bits equal 0xA25E opens the window, and status bit 1 reads 1 afterwards. The upper data bits of that write are not compared.
- R3: While the window is open, the next write to offset 0x30 (configuration) or offset 0x34 (timing) is stored, and the window closes in the same cycle. A following guarded write is then refused.
- R4: A write to a guarded register while the window is closed leaves that register unchanged and sets status bit 0.
- R5: Status bit 0 stays set until the status register is read. That read returns 1 and clears the bit, so a second read returns 0. If a refused write happens in the same cycle as a status read, the read returns the old value and the bit ends up set.
- R6: A write to offset 0x44 with any other low 16-bit value closes an open window.
- R7: Configuration data bit 3 drives `wprot_en`, bit 2 drives `large_page`, bit 1 drives `long_addr` and bit 0 drives `wide_bus`. Written bits above bit 3 are dropped and read back as zero.
- R8: The timing register stores the low TIME_W bits of the write data and drives them on `timing_word`. Reading it returns them zero-extended.
- R9: Reads of offsets 0x30 and 0x34 return the stored contents whether the window is open or closed, and a read never changes the window. Read data is valid the cycle after `rd_en`. Unmapped offsets read as 0.
- R10: Writes to the status offset or to unmapped offsets change nothing and do not close an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data, valid one cycle after rd_en |
| wprot_en | output | 1 | Write-protect enable (config bit 3) |
| large_page | output | 1 | Large-block page select (config bit 2) |
| long_addr | output | 1 | Five-byte addressing select (config bit 1) |
| wide_bus | output | 1 | 16-bit bus select (config bit 0) |
| timing_word | output | TIME_W | Timing register contents |

## Verification
The bench unlocks and then issues two guarded writes in a row. A unit that failed to relock would store the second value, so the bench checks that this value is refused. It also checks two other window cases. A wrong key must close the window; a unit that only cleared the window on a guarded write would accept a write it should refuse. Writes to the status offset and to unmapped offsets must leave the window open; a unit that closed it on any write would refuse a legitimate write. The violation flag is exercised in three ways: a double read that must clear it, a read issued in the same cycle as a refused write that must not lose the new violation, and a key whose upper bits are set, which must still unlock the unit because only the low 16 bits are compared.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_CFG  = 8'h30;
  localparam logic [OFS_W-1:0] OFS_TIME = 8'h34;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h40;
  localparam logic [OFS_W-1:0] OFS_LOCK = 8'h44;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E;
  localparam int CFG_W = 4;
  localparam int STAT_VIOL = 0;
  localparam int STAT_OPEN = 1;

  typedef struct packed {
    logic lock;
    logic cfg;
    logic tim;
    logic stat;
  } hit_t;
endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
  import cfgkey_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

  always_comb begin
    hit.lock = (addr == A_LOCK);
    hit.cfg  = (addr == A_CFG);
    hit.tim  = (addr == A_TIME);
    hit.stat = (addr == A_STAT);
  end
endmodule

// File: rtl/cfgkey_lock.sv
module cfgkey_lock
  import cfgkey_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  hit_t             wr_hit,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             rd_en,
  input  hit_t             rd_hit,
  output logic             win_open,
  output logic             viol,
  output logic             cfg_we,
  output logic             time_we
);
  logic key_ok;
  logic guarded_wr;

  assign key_ok     = (wr_key == UNLOCK_KEY);
  assign guarded_wr = wr_en && (wr_hit.cfg || wr_hit.tim);
  assign cfg_we     = wr_en && wr_hit.cfg && win_open;
  assign time_we    = wr_en && wr_hit.tim && win_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      viol     <= 1'b0;
    end else begin
      if (wr_en && wr_hit.lock)
        win_open <= key_ok;
      else if (guarded_wr)
        win_open <= 1'b0;

      if (guarded_wr && !win_open)
        viol <= 1'b1;
      else if (rd_en && rd_hit.stat)
        viol <= 1'b0;
    end
  end

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit.lock && wr_key == UNLOCK_KEY) |=> win_open);

  assert_one_shot_R3: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr_en && (wr_hit.cfg || wr_hit.tim)) |=> !win_open);

  assert_bad_key_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit.lock && wr_key != UNLOCK_KEY) |=> !win_open);

  assert_locked_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (!win_open && wr_en && (wr_hit.cfg || wr_hit.tim)) |=> viol);
endmodule

// File: rtl/cfgkey_store.sv
module cfgkey_store #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  assert_hold_unless_open_R4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
  import cfgkey_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TIME_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wprot_en,
  output logic              large_page,
  output logic              long_addr,
  output logic              wide_bus,
  output logic [TIME_W-1:0] timing_word
);
  hit_t whit, rhit;
  logic win_open, viol, cfg_we, time_we;
  logic [CFG_W-1:0] cfg_q;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:TIME_W];

  cfgkey_decode #(.ADDR_W(ADDR_W)) i_wdec (.addr(wr_addr), .hit(whit));
  cfgkey_decode #(.ADDR_W(ADDR_W)) i_rdec (.addr(rd_addr), .hit(rhit));

  cfgkey_lock i_lock (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_hit(whit), .wr_key(wr_data[KEY_W-1:0]),
    .rd_en(rd_en), .rd_hit(rhit),
    .win_open(win_open), .viol(viol),
    .cfg_we(cfg_we), .time_we(time_we)
  );

  cfgkey_store #(.WIDTH(CFG_W)) i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .d(wr_data[CFG_W-1:0]), .q(cfg_q)
  );

  cfgkey_store #(.WIDTH(TIME_W)) i_time (
    .clk(clk), .rst(rst), .we(time_we), .d(wr_data[TIME_W-1:0]), .q(timing_word)
  );

  assign wprot_en   = cfg_q[3];
  assign large_page = cfg_q[2];
  assign long_addr  = cfg_q[1];
  assign wide_bus   = cfg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (rhit.cfg)  rd_data[CFG_W-1:0]  <= cfg_q;
      if (rhit.tim)  rd_data[TIME_W-1:0] <= timing_word;
      if (rhit.stat) begin
        rd_data[STAT_VIOL] <= viol;
        rd_data[STAT_OPEN] <= win_open;
      end
    end
  end

  assert_viol_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (viol && !(rd_en && rhit.stat)) |=> viol);

  assert_read_keeps_window_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> $stable(win_open));
endmodule

// File: tb/test_keyed_cfg_regs.sv
module test_keyed_cfg_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        wprot_en, large_page, long_addr, wide_bus;
  logic [26:0] timing_word;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  keyed_cfg_regs i_keyed_cfg_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wprot_en(wprot_en), .large_page(large_page), .long_addr(long_addr),
    .wide_bus(wide_bus), .timing_word(timing_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] cfg_pins();
    return {28'd0, wprot_en, large_page, long_addr, wide_bus};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cfg pins", cfg_pins(), 32'h0);
    check("R1 timing pins", {5'd0, timing_word}, 32'h0);
    rd(8'h30, v); check("R1 cfg read", v, 32'h0);
    rd(8'h40, v); check("R1 status", v, 32'h0);
  endtask

  task automatic t_unlock_one_shot();
    logic [31:0] v;
    wr(8'h44, 32'h0000_A25E);
    rd(8'h40, v); check("R2 window open", v, 32'h2);
    wr(8'h30, 32'h0000_00FA);
    check("R7 cfg pins", cfg_pins(), 32'hA);
    rd(8'h30, v); check("R7 cfg read", v, 32'hA);
    rd(8'h40, v); check("R3 relocked", v, 32'h0);
    wr(8'h34, 32'h0000_0123);
    rd(8'h34, v); check("R3 second write refused", v, 32'h0);
    check("R4 timing unchanged", {5'd0, timing_word}, 32'h0);
    rd(8'h40, v); check("R4 violation set", v, 32'h1);
    rd(8'h40, v); check("R5 cleared by read", v, 32'h0);
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    wr(8'h44, 32'h0000_A25E);
    wr(8'h44, 32'h0000_1234);
    rd(8'h40, v); check("R6 window closed", v, 32'h0);
    wr(8'h30, 32'h5);
    check("R6 cfg kept", cfg_pins(), 32'hA);
    rd(8'h40, v); check("R6 violation", v, 32'h1);
  endtask

  task automatic t_timing_upper_key();
    logic [31:0] v;
    wr(8'h44, 32'hFFFF_A25E);
    rd(8'h40, v); check("R2 upper bits ignored", v, 32'h2);
    wr(8'h34, 32'hFFFF_FFFF);
    check("R8 timing pins", {5'd0, timing_word}, 32'h07FF_FFFF);
    rd(8'h34, v); check("R8 timing read", v, 32'h07FF_FFFF);
  endtask

  task automatic t_other_offsets();
    logic [31:0] v;
    wr(8'h44, 32'h0000_A25E);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0003);
    rd(8'h40, v); check("R10 window still open", v, 32'h2);
    rd(8'h30, v); check("R9 read while open", v, 32'hA);
    rd(8'h34, v); check("R9 timing read while open", v, 32'h07FF_FFFF);
    rd(8'h10, v); check("R9 unmapped reads 0", v, 32'h0);
    rd(8'h40, v); check("R9 reads keep window", v, 32'h2);
    wr(8'h30, 32'h5);
    check("R10 write accepted", cfg_pins(), 32'h5);
  endtask

  task automatic t_viol_during_read();
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h30; wr_data = 32'hF;
    rd_en = 1'b1; rd_addr = 8'h40;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R5 read returns old", rd_data, 32'h0);
    check("R4 cfg unchanged", cfg_pins(), 32'h5);
    rd(8'h40, v); check("R5 new violation kept", v, 32'h1);
    rd(8'h40, v); check("R5 cleared", v, 32'h0);
  endtask

  initial begin
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unlock_one_shot();
    t_bad_key();
    t_timing_upper_key();
    t_other_offsets();
    t_viol_during_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule